// File: doc/BRIEF.md
# Level-Based Preemptive Interrupt Arbiter

This block sits beside a processor core and decides which of a parameterized set of interrupt sources, if any, may interrupt the code that is running now. Each source has its own enable, pending flag, trigger type, vectoring choice, level and priority. Every cycle the arbiter picks the best candidate among the pending and enabled sources and registers the result. It raises a request to the core only when the candidate's level is strictly above the core's current interrupt level. A handler running at one level can therefore be preempted by a source with a higher level, which is how nesting works.

Software configures the arbiter through a single-cycle read/write register port. The current interrupt level sits in one of these registers, as do a global enable, a trap-vector register whose two low bits select the arbiter's operating mode, a vector table base and one common handler address. A read of the take-next register returns the entry address of the request that is active now. The same read claims that source and raises the current level to the source's level. A handler can therefore move straight on to the next interrupt without first returning.

Top module: `irq_level_arb`

## Requirements
- R1: After reset every register reads zero, `irq_req` is 0 and `reg_rdata` is 0.
- R2: For an edge-triggered source (field bit 2 = 1), a 0-to-1 change on its `irq_in` bit sets the pending flag. For a level-triggered source (bit 2 = 0), the pending flag follows `irq_in`, delayed by one register.
- R3: The candidate is chosen only among sources that are both pending and enabled. The higher level wins; if levels are equal, the higher priority wins; if both are equal, the lower source index wins.
- R4: `irq_req` is 1 only when all three of these hold: the global enable (register 0, bit 0) is 1, the trap-vector bits [1:0] equal 2'b11, and the candidate's level is strictly greater than the current level (register 4).
- R5: `irq_req`, `irq_id` and `irq_level` are registered one cycle after the pending flags, so a rising edge on an input reaches `irq_req` at the second clock edge.
- R6: Reading register 5 while `irq_req` is 1 claims the requested source. The read returns the vector base (register 2) plus 4 × the source index if the source's vectored bit (bit 3) is 1, and otherwise the common handler (register 3). The claim sets the current level to the source's level and clears the pending flag of an edge-triggered source.
- R7: Claiming a level-triggered source leaves its pending flag set.
- R8: Reading register 5 while `irq_req` is 0 returns zero and changes no pending flag and no current level.
- R9: Reads return data one cycle after `reg_rd`, with `reg_rvalid` high in that cycle. Source i sits at word address 8+i with these fields: bit 0 pending, bit 1 enable, bit 2 edge-triggered, bit 3 vectored, bits [8 +: LVL_W] level and bits [16 +: PRI_W] priority. Registers 0 to 4 read back what was written to them.
- R10: A software write to the pending bit of a level-triggered source has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Raw interrupt lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| irq_req | output | 1 | Interrupt request to the core |
| irq_id | output | ID_W | Index of the requesting source |
| irq_level | output | LVL_W | Level of the requesting source |

## Verification
The assertions assume that the register port carries at most one operation per cycle, so `reg_wr` and `reg_rd` are never high together. They also assume that addresses above the last source word are never used. The bench drives every access through one task that raises a single strobe for exactly one cycle, and it touches only mapped addresses. The raw interrupt lines change only on the falling clock edge. Each input then holds steady for at least two cycles before the bench samples the request outputs, so every arbitration result it checks has settled.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int REG_GCTL   = 0;
  localparam int REG_TVEC   = 1;
  localparam int REG_VTBASE = 2;
  localparam int REG_COMMON = 3;
  localparam int REG_CURLVL = 4;
  localparam int REG_NEXT   = 5;
  localparam int SRC_BASE   = 8;

  localparam int FLD_PEND = 0;
  localparam int FLD_EN   = 1;
  localparam int FLD_EDGE = 2;
  localparam int FLD_VEC  = 3;
  localparam int FLD_LVL  = 8;
  localparam int FLD_PRI  = 16;

  localparam logic [1:0] MODE_LOCAL = 2'b11;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int PRI_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              irq_in,
  input  logic [NUM_SRC-1:0]              cfg_we,
  input  logic                            wr_pend,
  input  logic                            wr_en,
  input  logic                            wr_edge,
  input  logic                            wr_vec,
  input  logic [LVL_W-1:0]                wr_lvl,
  input  logic [PRI_W-1:0]                wr_pri,
  input  logic [NUM_SRC-1:0]              claim,
  output logic [NUM_SRC-1:0]              pend_q,
  output logic [NUM_SRC-1:0]              en_q,
  output logic [NUM_SRC-1:0]              edge_q,
  output logic [NUM_SRC-1:0]              vec_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_q,
  output logic [NUM_SRC-1:0][PRI_W-1:0]   pri_q
);
  logic [NUM_SRC-1:0] irq_d;
  logic [NUM_SRC-1:0] rise;

  assign rise = irq_in & ~irq_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d  <= '0;
      pend_q <= '0;
      en_q   <= '0;
      edge_q <= '0;
      vec_q  <= '0;
      lvl_q  <= '0;
      pri_q  <= '0;
    end else begin
      irq_d <= irq_in;
      for (int i = 0; i < NUM_SRC; i++) begin
        // pending update uses the trigger type held before this edge
        if (!edge_q[i])      pend_q[i] <= irq_in[i];
        else if (rise[i])    pend_q[i] <= 1'b1;
        else if (claim[i])   pend_q[i] <= 1'b0;
        else if (cfg_we[i])  pend_q[i] <= wr_pend;
        if (cfg_we[i]) begin
          en_q[i]   <= wr_en;
          edge_q[i] <= wr_edge;
          vec_q[i]  <= wr_vec;
          lvl_q[i]  <= wr_lvl;
          pri_q[i]  <= wr_pri;
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
      a_r2_level_mirror: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(!edge_q[g])) |-> (pend_q[g] == $past(irq_in[g])));
    end
  endgenerate
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int PRI_W   = 3,
  parameter int ID_W    = 3
) (
  input  logic [NUM_SRC-1:0]            cand,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  input  logic [NUM_SRC-1:0][PRI_W-1:0] pri,
  output logic                          found,
  output logic [ID_W-1:0]               best_id,
  output logic [LVL_W-1:0]              best_lvl
);
  logic [PRI_W-1:0] best_pri;

  // ascending scan, replace only on strictly better: ties go to lower index
  always_comb begin
    found    = 1'b0;
    best_id  = '0;
    best_lvl = '0;
    best_pri = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!found || (lvl[i] > best_lvl) ||
                      ((lvl[i] == best_lvl) && (pri[i] > best_pri)))) begin
        found    = 1'b1;
        best_id  = ID_W'(i);
        best_lvl = lvl[i];
        best_pri = pri[i];
      end
    end
  end
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int LVL_W   = 3,
  parameter int PRI_W   = 3,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  localparam int ID_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               reg_rvalid,
  output logic               irq_req,
  output logic [ID_W-1:0]    irq_id,
  output logic [LVL_W-1:0]   irq_level
);
  logic              gie_q;
  logic [DATA_W-1:0] tvec_q, vtbase_q, common_q;
  logic [LVL_W-1:0]  cur_lvl_q;

  logic [NUM_SRC-1:0]            pend, en, edge_t, vec;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl;
  logic [NUM_SRC-1:0][PRI_W-1:0] pri;
  logic [NUM_SRC-1:0]            cfg_we, claim_vec;

  logic              sel_found;
  logic [ID_W-1:0]   sel_id;
  logic [LVL_W-1:0]  sel_lvl;
  logic              req_q;
  logic [ID_W-1:0]   win_id_q;
  logic [LVL_W-1:0]  win_lvl_q;

  logic              tn_read, tn_claim, mode_ok;
  logic [DATA_W-1:0] handler, rd_val;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++)
      cfg_we[i] = reg_wr && (reg_addr == ADDR_W'(SRC_BASE + i));
  end

  irq_src_bank #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRI_W(PRI_W)) u_bank (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cfg_we(cfg_we),
    .wr_pend(reg_wdata[FLD_PEND]), .wr_en(reg_wdata[FLD_EN]),
    .wr_edge(reg_wdata[FLD_EDGE]), .wr_vec(reg_wdata[FLD_VEC]),
    .wr_lvl(reg_wdata[FLD_LVL +: LVL_W]), .wr_pri(reg_wdata[FLD_PRI +: PRI_W]),
    .claim(claim_vec), .pend_q(pend), .en_q(en), .edge_q(edge_t),
    .vec_q(vec), .lvl_q(lvl), .pri_q(pri)
  );

  irq_select #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .PRI_W(PRI_W), .ID_W(ID_W)) u_sel (
    .cand(pend & en), .lvl(lvl), .pri(pri),
    .found(sel_found), .best_id(sel_id), .best_lvl(sel_lvl)
  );

  assign mode_ok   = (tvec_q[1:0] == MODE_LOCAL);
  assign tn_read   = reg_rd && (reg_addr == ADDR_W'(REG_NEXT));
  assign tn_claim  = tn_read && req_q;
  assign claim_vec = tn_claim ? (NUM_SRC'(1) << win_id_q) : '0;
  assign handler   = vec[win_id_q] ? (vtbase_q + (DATA_W'(win_id_q) << 2)) : common_q;

  always_comb begin
    rd_val = '0;
    case (reg_addr)
      ADDR_W'(REG_GCTL):   rd_val[0] = gie_q;
      ADDR_W'(REG_TVEC):   rd_val = tvec_q;
      ADDR_W'(REG_VTBASE): rd_val = vtbase_q;
      ADDR_W'(REG_COMMON): rd_val = common_q;
      ADDR_W'(REG_CURLVL): rd_val[LVL_W-1:0] = cur_lvl_q;
      ADDR_W'(REG_NEXT):   rd_val = req_q ? handler : '0;
      default: begin
        for (int i = 0; i < NUM_SRC; i++) begin
          if (reg_addr == ADDR_W'(SRC_BASE + i)) begin
            rd_val[FLD_PEND]           = pend[i];
            rd_val[FLD_EN]             = en[i];
            rd_val[FLD_EDGE]           = edge_t[i];
            rd_val[FLD_VEC]            = vec[i];
            rd_val[FLD_LVL +: LVL_W]   = lvl[i];
            rd_val[FLD_PRI +: PRI_W]   = pri[i];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q      <= 1'b0;
      tvec_q     <= '0;
      vtbase_q   <= '0;
      common_q   <= '0;
      cur_lvl_q  <= '0;
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
      req_q      <= 1'b0;
      win_id_q   <= '0;
      win_lvl_q  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_val;
      if (reg_wr) begin
        case (reg_addr)
          ADDR_W'(REG_GCTL):   gie_q     <= reg_wdata[0];
          ADDR_W'(REG_TVEC):   tvec_q    <= reg_wdata;
          ADDR_W'(REG_VTBASE): vtbase_q  <= reg_wdata;
          ADDR_W'(REG_COMMON): common_q  <= reg_wdata;
          ADDR_W'(REG_CURLVL): cur_lvl_q <= reg_wdata[LVL_W-1:0];
          default: ;
        endcase
      end
      if (tn_claim) cur_lvl_q <= win_lvl_q;
      win_id_q  <= sel_id;
      win_lvl_q <= sel_lvl;
      // a claimed source must not be offered again before the result refreshes
      req_q <= !tn_claim && sel_found && gie_q && mode_ok && (sel_lvl > cur_lvl_q);
    end
  end

  assign irq_req   = req_q;
  assign irq_id    = win_id_q;
  assign irq_level = win_lvl_q;

  a_r4_req_gated: assert property (@(posedge clk) disable iff (rst)
    req_q |-> ($past(gie_q) && ($past(tvec_q[1:0]) == MODE_LOCAL)));
  a_r4_strict_level: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (win_lvl_q > $past(cur_lvl_q)));
  a_r8_empty_next: assert property (@(posedge clk) disable iff (rst)
    (tn_read && !req_q) |=> (reg_rdata == '0));
  a_r6_level_takeover: assert property (@(posedge clk) disable iff (rst)
    tn_claim |=> ((cur_lvl_q == $past(win_lvl_q)) && !req_q));
  a_r9_read_valid: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);
endmodule

// File: tb/tb_irq_level_arb.sv
module tb_irq_level_arb;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_rvalid, irq_req;
  logic [2:0] irq_id, irq_level;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  irq_level_arb dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_req(irq_req), .irq_id(irq_id), .irq_level(irq_level)
  );

  function automatic logic [31:0] cfg(bit en, bit edg, bit vec, int lvl, int pri);
    return (32'(pri) << 16) | (32'(lvl) << 8) | (32'(vec) << 3) | (32'(edg) << 2) | (32'(en) << 1);
  endfunction

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (!rst && reg_rvalid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R9: unexpected read data %h, expected none", reg_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          miscompares++;
          $display("FAIL %s: read %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = 5'(a);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk(bit er, int eid, string t);
    vectors++;
    if (irq_req !== er || (er && irq_id !== 3'(eid))) begin
      miscompares++;
      $display("FAIL %s: req=%0b id=%0d expected req=%0b id=%0d", t, irq_req, irq_id, er, eid);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk(0, 0, "R1");
    for (int a = 0; a < 5; a++) rd(a, 32'h0, "R1");
    rd(13, 32'h0, "R1");

    wr(1, 32'h0000_1003);
    wr(2, 32'h8000_0000);
    wr(3, 32'h4000_0100);
    wr(0, 32'h1);
    wr(9,  cfg(0, 1, 0, 7, 0));
    wr(10, cfg(1, 1, 1, 3, 1));
    wr(13, cfg(1, 1, 0, 3, 4));
    wr(14, cfg(1, 0, 1, 5, 0));
    rd(1, 32'h0000_1003, "R9");
    rd(0, 32'h1, "R9");
    rd(13, cfg(1, 1, 0, 3, 4), "R9");
    idle(2);

    // R5 exact latency: pending after edge 1, request after edge 2
    irq_in[2] = 1'b1;
    @(negedge clk);
    chk(0, 0, "R5 first edge");
    @(negedge clk);
    chk(1, 2, "R5 second edge");
    rd(10, cfg(1, 1, 1, 3, 1) | 32'h1, "R2 edge pending");

    irq_in[5] = 1'b1; idle(2);
    chk(1, 5, "R3 priority tiebreak");
    irq_in[1] = 1'b1; idle(2);
    chk(1, 5, "R3 disabled ignored");
    irq_in[6] = 1'b1; idle(2);
    chk(1, 6, "R3 higher level");

    wr(4, 32'd5); idle(2);
    chk(0, 0, "R4 equal level");
    wr(4, 32'd4); idle(2);
    chk(1, 6, "R4 above level");
    wr(0, 32'h0); idle(2);
    chk(0, 0, "R4 global enable");
    wr(0, 32'h1); wr(1, 32'h0000_1000); idle(2);
    chk(0, 0, "R4 mode bits");
    wr(1, 32'h0000_1003); idle(2);
    chk(1, 6, "R4 mode restored");

    rd(5, 32'h8000_0018, "R6 vectored entry");
    idle(1);
    rd(4, 32'd5, "R6 level raised");
    rd(14, cfg(1, 0, 1, 5, 0) | 32'h1, "R7 level source kept");
    chk(0, 0, "R6 nothing above");

    rd(5, 32'h0, "R8 empty take");
    rd(4, 32'd5, "R8 level unchanged");
    rd(13, cfg(1, 1, 0, 3, 4) | 32'h1, "R8 pending unchanged");

    irq_in[6] = 1'b0; idle(2);
    rd(14, cfg(1, 0, 1, 5, 0), "R2 level follows input");

    wr(4, 32'd2); idle(2);
    chk(1, 5, "R6 next candidate");
    rd(5, 32'h4000_0100, "R6 common entry");
    idle(1);
    rd(13, cfg(1, 1, 0, 3, 4), "R6 edge cleared");
    rd(4, 32'd3, "R6 level raised");

    wr(4, 32'd2); idle(2);
    chk(1, 2, "R3 remaining source");
    rd(5, 32'h8000_0008, "R6 vectored entry id2");
    idle(1);
    rd(10, cfg(1, 1, 1, 3, 1), "R6 edge cleared id2");

    wr(14, cfg(1, 0, 1, 5, 0) | 32'h1); idle(2);
    rd(14, cfg(1, 0, 1, 5, 0), "R10 write ignored");
    idle(3);

    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R9: %0d reads unanswered, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule